// File: doc/BRIEF.md
# Level-Building Connected-Word Search Engine

This block runs the second stage of a two-stage dynamic-programming search for connected-word recognition. A first stage elsewhere scores every vocabulary word against every candidate segment of the utterance. This block keeps only the best word and its score for each segment. From those it builds, level by level, the lowest total distance for a string of exactly `l` words that ends at each frame. For every level and end frame it stores where the last word started and which word it was. When the stream ends, it picks the best number of words and walks the stored pointers back to produce the recognised word string.

Frames are numbered 1 to `M`. A segment (s, e) covers frames s through e inclusive and must satisfy 1 ≤ s < e ≤ M. A `start` pulse in idle opens a search. The per-word segment scores then enter over a valid/ready stream in a fixed order. After the search, the result and the word string leave over a second valid/ready stream. The datapath is a chain of identical per-level cells. Each cell passes its state only to the next cell in the chain, and it uses only adders and comparators.

Top module: `lb_dp_engine`

## Requirements
- R1: For each segment, the block keeps the minimum of the `V` word scores and the index of that word. If several words share the minimum, the lowest word index is kept.
- R2: Scores are accepted in this order: end frame e from 2 to M (outermost loop), then start frame s from 1 to e−1, then word index 0 to V−1 (innermost loop). That gives V·M(M−1)/2 scores per search. `in_ready` is low after reset, in idle, and from the cycle after the final score is accepted.
- R3: Let A(l, e) be the best total for exactly l words ending at frame e. A(l, e) is the minimum, over s from 1 to e−1, of the segment best for (s, e) plus A(l−1, s−1). The base level has A(0, 0) = 0 and every other A(0, e) unreachable. `res_total` reports the chosen A(l, M).
- R4: When two start frames give the same sum, the earlier start frame wins. This affects which word string is traced back.
- R5: Sums saturate at the all-ones value of `ACC_W` bits, which means "unreachable". Any unreachable term keeps the sum unreachable, so an unreachable level can never win.
- R6: The block chooses the level l in 1..L with the lowest A(l, M). If levels tie, the smaller level wins. `res_levels` reports the chosen level.
- R7: Word indices leave on `out_word`, last word of the utterance first. `out_last` is high on the first word of the utterance, which is the final beat. While `out_valid` is high and `out_ready` is low, `out_word` and `out_last` hold.
- R8: `done` is high for exactly one cycle, in the cycle after the final output handshake. `res_total` and `res_levels` are valid from the first `out_valid` and hold until the next start.
- R9: A `start` pulse while a search is streaming, draining or tracing back has no effect on that search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a new search when idle |
| in_valid | input | 1 | Segment word score present |
| in_ready | output | 1 | Engine accepts a score this cycle |
| in_score | input | SCORE_W | Score of one word on one segment |
| out_valid | output | 1 | A traced word index is presented |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | $clog2(V) | Word index, last word of the utterance first |
| out_last | output | 1 | Marks the final word beat (first word of the utterance) |
| res_total | output | ACC_W | Best accumulated distance at frame M |
| res_levels | output | $clog2(L+1) | Number of words in the best string |
| done | output | 1 | One-cycle pulse after traceback ends |

## Verification
The bench aims at ties at every decision point: word index, start frame and level. Score ranges of 0..1 and 0..3, and one table of all zeros, make ties common. A design that let a later candidate win a tie would return a different word string with the same total. Random score tables reach many level/frame cells that no legal string can reach. A design whose adders wrap instead of saturating would turn those cells into tiny totals and report too many words. Random stalls on the output check that a word holds steady under back-pressure. Start pulses inside a busy search check that the search is not restarted or corrupted.

// File: rtl/lb_dp_pkg.sv
package lb_dp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_STREAM,
      ST_DRAIN,
      ST_PICK,
      ST_TRACE
   } eng_state_t;

endpackage

// File: rtl/lb_vocab_min.sv
module lb_vocab_min #(
   parameter int M       = 8,
   parameter int V       = 4,
   parameter int SCORE_W = 8,
   parameter int FW      = 4,
   parameter int VW      = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               enable,
   input  logic               in_valid,
   input  logic [SCORE_W-1:0] in_score,
   output logic               in_ready,
   output logic               stream_done,
   output logic               tok_valid,
   output logic [FW-1:0]      tok_s,
   output logic [FW-1:0]      tok_e,
   output logic               tok_last,
   output logic [SCORE_W-1:0] tok_score,
   output logic [VW-1:0]      tok_word
);

   logic [VW-1:0]      v_q;
   logic [FW-1:0]      s_q;
   logic [FW-1:0]      e_q;
   logic [SCORE_W-1:0] run_q;
   logic [VW-1:0]      runw_q;
   logic               done_q;

   logic               take;
   logic               better;
   logic               last_v;
   logic               last_s;
   logic               last_all;
   logic [SCORE_W-1:0] min_score;
   logic [VW-1:0]      min_word;

   assign in_ready    = enable && !done_q;
   assign stream_done = done_q;
   assign take        = in_valid && in_ready;

   always_comb begin
      better    = (v_q == '0) || (in_score < run_q);
      last_v    = (v_q == VW'(V - 1));
      last_s    = (s_q == e_q - FW'(1));
      last_all  = last_v && last_s && (e_q == FW'(M));
      min_score = better ? in_score : run_q;
      min_word  = better ? v_q : runw_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q       <= '0;
         s_q       <= FW'(1);
         e_q       <= FW'(2);
         run_q     <= '0;
         runw_q    <= '0;
         done_q    <= 1'b0;
         tok_valid <= 1'b0;
         tok_s     <= '0;
         tok_e     <= '0;
         tok_last  <= 1'b0;
         tok_score <= '0;
         tok_word  <= '0;
      end else if (clear) begin
         v_q       <= '0;
         s_q       <= FW'(1);
         e_q       <= FW'(2);
         done_q    <= 1'b0;
         tok_valid <= 1'b0;
      end else begin
         tok_valid <= 1'b0;
         if (take) begin
            run_q  <= min_score;
            runw_q <= min_word;
            if (last_v) begin
               v_q       <= '0;
               tok_valid <= 1'b1;
               tok_s     <= s_q;
               tok_e     <= e_q;
               tok_last  <= last_s;
               tok_score <= min_score;
               tok_word  <= min_word;
               if (last_s) begin
                  s_q <= FW'(1);
                  e_q <= e_q + FW'(1);
               end else begin
                  s_q <= s_q + FW'(1);
               end
               if (last_all) done_q <= 1'b1;
            end else begin
               v_q <= v_q + VW'(1);
            end
         end
      end
   end

   // R2: every segment handed to the level chain satisfies 1 <= s < e
   a_r2_segment_order: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid |-> (tok_s >= FW'(1)) && (tok_s < tok_e));

   // R1: the kept minimum never exceeds the last word score of its segment
   a_r1_min_not_above_last: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid |-> tok_score <= $past(in_score));

endmodule

// File: rtl/lb_level_pe.sv
module lb_level_pe #(
   parameter int M       = 8,
   parameter int SCORE_W = 8,
   parameter int ACC_W   = 12,
   parameter int FW      = 4,
   parameter int VW      = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               tok_valid_i,
   input  logic [FW-1:0]      tok_s_i,
   input  logic [FW-1:0]      tok_e_i,
   input  logic               tok_last_i,
   input  logic [SCORE_W-1:0] tok_score_i,
   input  logic [VW-1:0]      tok_word_i,
   input  logic [ACC_W-1:0]   pv_i,
   output logic               tok_valid_o,
   output logic [FW-1:0]      tok_s_o,
   output logic [FW-1:0]      tok_e_o,
   output logic               tok_last_o,
   output logic [SCORE_W-1:0] tok_score_o,
   output logic [VW-1:0]      tok_word_o,
   output logic [ACC_W-1:0]   pv_o,
   output logic [ACC_W-1:0]   end_acc,
   input  logic [FW-1:0]      rd_frame,
   output logic [FW-1:0]      rd_s,
   output logic [VW-1:0]      rd_w
);

   localparam logic [ACC_W-1:0] ACC_MAX = '1;

   logic [ACC_W-1:0] acc_q [0:M];
   logic [FW-1:0]    bps_q [0:M];
   logic [VW-1:0]    bpw_q [0:M];

   logic [ACC_W-1:0] best_q;
   logic [FW-1:0]    bs_q;
   logic [VW-1:0]    bw_q;

   logic [ACC_W:0]   wide;
   logic [ACC_W-1:0] cand;
   logic             take_it;
   logic [ACC_W-1:0] nb;
   logic [FW-1:0]    ns;
   logic [VW-1:0]    nw;

   always_comb begin
      wide    = {1'b0, pv_i} + (ACC_W + 1)'(tok_score_i);
      cand    = ((pv_i == ACC_MAX) || (wide >= {1'b0, ACC_MAX})) ? ACC_MAX : wide[ACC_W-1:0];
      take_it = (tok_s_i == FW'(1)) || (cand < best_q);
      nb      = take_it ? cand : best_q;
      ns      = take_it ? tok_s_i : bs_q;
      nw      = take_it ? tok_word_i : bw_q;
   end

   always_ff @(posedge clk) begin
      if (clear) begin
         for (int i = 0; i <= M; i++) acc_q[i] <= ACC_MAX;
      end else if (tok_valid_i && tok_last_i) begin
         acc_q[tok_e_i] <= nb;
         bps_q[tok_e_i] <= ns;
         bpw_q[tok_e_i] <= nw;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_q      <= ACC_MAX;
         bs_q        <= '0;
         bw_q        <= '0;
         tok_valid_o <= 1'b0;
         tok_s_o     <= '0;
         tok_e_o     <= '0;
         tok_last_o  <= 1'b0;
         tok_score_o <= '0;
         tok_word_o  <= '0;
         pv_o        <= ACC_MAX;
      end else begin
         tok_valid_o <= tok_valid_i && !clear;
         if (tok_valid_i) begin
            best_q      <= nb;
            bs_q        <= ns;
            bw_q        <= nw;
            tok_s_o     <= tok_s_i;
            tok_e_o     <= tok_e_i;
            tok_last_o  <= tok_last_i;
            tok_score_o <= tok_score_i;
            tok_word_o  <= tok_word_i;
            pv_o        <= acc_q[tok_s_i - FW'(1)];
         end
      end
   end

   assign end_acc = acc_q[M];
   assign rd_s    = bps_q[rd_frame];
   assign rd_w    = bpw_q[rd_frame];

   // R3: a committed cell is never worse than the closing candidate of its end frame
   a_r3_commit_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid_i && tok_last_i && !clear) |=> acc_q[$past(tok_e_i)] <= $past(cand));

endmodule

// File: rtl/lb_dp_engine.sv
module lb_dp_engine
   import lb_dp_pkg::*;
#(
   parameter int M       = 8,
   parameter int V       = 4,
   parameter int L       = 3,
   parameter int SCORE_W = 8,
   parameter int ACC_W   = 12,
   localparam int FW     = $clog2(M + 1),
   localparam int VW     = $clog2(V),
   localparam int LW     = $clog2(L + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [SCORE_W-1:0] in_score,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [VW-1:0]      out_word,
   output logic               out_last,
   output logic [ACC_W-1:0]   res_total,
   output logic [LW-1:0]      res_levels,
   output logic               done
);

   localparam logic [ACC_W-1:0] ACC_MAX = '1;

   if (M < 2) begin : g_chk_m
      $error("lb_dp_engine: M must be at least 2");
   end
   if (V < 2) begin : g_chk_v
      $error("lb_dp_engine: V must be at least 2");
   end
   if (L < 1) begin : g_chk_l
      $error("lb_dp_engine: L must be at least 1");
   end
   if (ACC_W < SCORE_W + LW + 1) begin : g_chk_w
      $error("lb_dp_engine: ACC_W too narrow for L saturating sums");
   end

   eng_state_t state_q;
   logic       clear;
   logic       fe_done;

   logic               tv  [0:L];
   logic [FW-1:0]      ts  [0:L];
   logic [FW-1:0]      te  [0:L];
   logic               tl  [0:L];
   logic [SCORE_W-1:0] tsc [0:L];
   logic [VW-1:0]      tw  [0:L];
   logic [ACC_W-1:0]   pv  [0:L];
   logic [ACC_W-1:0]   endv [1:L];
   logic [FW-1:0]      rs   [1:L];
   logic [VW-1:0]      rw   [1:L];

   logic [LW-1:0]    cur_l_q;
   logic [FW-1:0]    cur_e_q;
   logic [ACC_W-1:0] best_v;
   logic [LW-1:0]    best_l;
   logic [VW-1:0]    sel_w;
   logic [FW-1:0]    sel_s;
   logic             done_q;

   assign clear = (state_q == ST_IDLE) && start;

   lb_vocab_min #(
      .M(M), .V(V), .SCORE_W(SCORE_W), .FW(FW), .VW(VW)
   ) u_front (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .enable     (state_q == ST_STREAM),
      .in_valid   (in_valid),
      .in_score   (in_score),
      .in_ready   (in_ready),
      .stream_done(fe_done),
      .tok_valid  (tv[0]),
      .tok_s      (ts[0]),
      .tok_e      (te[0]),
      .tok_last   (tl[0]),
      .tok_score  (tsc[0]),
      .tok_word   (tw[0])
   );

   assign pv[0] = (ts[0] == FW'(1)) ? '0 : ACC_MAX;

   for (genvar l = 1; l <= L; l++) begin : g_level
      lb_level_pe #(
         .M(M), .SCORE_W(SCORE_W), .ACC_W(ACC_W), .FW(FW), .VW(VW)
      ) u_pe (
         .clk        (clk),
         .rst_n      (rst_n),
         .clear      (clear),
         .tok_valid_i(tv[l-1]),
         .tok_s_i    (ts[l-1]),
         .tok_e_i    (te[l-1]),
         .tok_last_i (tl[l-1]),
         .tok_score_i(tsc[l-1]),
         .tok_word_i (tw[l-1]),
         .pv_i       (pv[l-1]),
         .tok_valid_o(tv[l]),
         .tok_s_o    (ts[l]),
         .tok_e_o    (te[l]),
         .tok_last_o (tl[l]),
         .tok_score_o(tsc[l]),
         .tok_word_o (tw[l]),
         .pv_o       (pv[l]),
         .end_acc    (endv[l]),
         .rd_frame   (cur_e_q),
         .rd_s       (rs[l]),
         .rd_w       (rw[l])
      );
   end

   always_comb begin
      best_v = endv[1];
      best_l = LW'(1);
      for (int l = 2; l <= L; l++) begin
         if (endv[l] < best_v) begin
            best_v = endv[l];
            best_l = LW'(l);
         end
      end
   end

   always_comb begin
      sel_w = rw[1];
      sel_s = rs[1];
      for (int l = 1; l <= L; l++) begin
         if (cur_l_q == LW'(l)) begin
            sel_w = rw[l];
            sel_s = rs[l];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cur_l_q    <= '0;
         cur_e_q    <= '0;
         res_total  <= '0;
         res_levels <= '0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE:   if (start) state_q <= ST_STREAM;
            ST_STREAM: if (fe_done) state_q <= ST_DRAIN;
            ST_DRAIN:  if (tv[L] && tl[L] && (te[L] == FW'(M))) state_q <= ST_PICK;
            ST_PICK: begin
               res_total  <= best_v;
               res_levels <= best_l;
               cur_l_q    <= best_l;
               cur_e_q    <= FW'(M);
               state_q    <= ST_TRACE;
            end
            ST_TRACE: begin
               if (out_ready) begin
                  if (cur_l_q == LW'(1)) begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     cur_l_q <= cur_l_q - LW'(1);
                     cur_e_q <= sel_s - FW'(1);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign out_valid = (state_q == ST_TRACE);
   assign out_word  = sel_w;
   assign out_last  = (state_q == ST_TRACE) && (cur_l_q == LW'(1));
   assign done      = done_q;

   // R7: a stalled word beat holds its contents
   a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid && $stable(out_word) && $stable(out_last));

   // R8: done follows the handshake of the final word beat
   a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(out_valid && out_ready && out_last));

   // R9: input is never accepted while results are being traced
   a_r9_no_input_in_trace: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R5: no level of one or more words can end at frame 0
   a_r5_frame0_unreachable: assert property (@(posedge clk) disable iff (!rst_n)
      (tv[L] && ts[L] == FW'(1)) |-> pv[L] == ACC_MAX);

   // R2: the last cell only sees ordered segments
   a_r2_tail_order: assert property (@(posedge clk) disable iff (!rst_n)
      tv[L] |-> (ts[L] < te[L]) && (tw[L] <= VW'(V - 1)) && (tsc[L] == tsc[L]));

endmodule

// File: tb/test_lb_dp_engine.sv
`timescale 1ns/1ps
module test_lb_dp_engine;

   localparam int M = 8;
   localparam int V = 4;
   localparam int L = 3;
   localparam int SW = 8;
   localparam int AW = 12;
   localparam int AMAX = (1 << AW) - 1;
   localparam int NCASE = 6;

   localparam int unsigned C_SEED [NCASE] = '{11, 22, 33, 44, 55, 66};
   localparam int          C_MAX  [NCASE] = '{255, 3, 0, 1, 40, 255};
   localparam int          C_RDY  [NCASE] = '{100, 50, 70, 30, 90, 60};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          in_valid = 1'b0;
   logic [SW-1:0] in_score = '0;
   logic          out_ready = 1'b0;
   logic          in_ready;
   logic          out_valid;
   logic [1:0]    out_word;
   logic          out_last;
   logic [AW-1:0] res_total;
   logic [1:0]    res_levels;
   logic          done;

   always #4 clk = ~clk;

   lb_dp_engine #(.M(M), .V(V), .L(L), .SCORE_W(SW), .ACC_W(AW)) i_lb_dp_engine (
      .clk(clk), .rst_n(rst_n), .start(start),
      .in_valid(in_valid), .in_ready(in_ready), .in_score(in_score),
      .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
      .out_last(out_last), .res_total(res_total), .res_levels(res_levels),
      .done(done)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   int sc  [0:M][0:M][0:V-1];
   int dt  [0:M][0:M];
   int dw  [0:M][0:M];
   int acc [0:L][0:M];
   int rbs [0:L][0:M];
   int rbw [0:L][0:M];
   int exp_total, exp_lv;
   int exp_words [0:L-1];

   task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic build(input int unsigned seed, input int maxv);
      void'($urandom(seed));
      for (int e = 0; e <= M; e++)
         for (int s = 0; s <= M; s++)
            for (int v = 0; v < V; v++)
               sc[e][s][v] = (maxv == 0) ? 0 : int'($urandom % (maxv + 1));
   endtask

   function automatic int sat(input int a, input int b);
      if (a == AMAX || a + b >= AMAX) return AMAX;
      return a + b;
   endfunction

   task automatic reference();
      int e;
      for (int ee = 2; ee <= M; ee++)
         for (int s = 1; s < ee; s++) begin
            dt[s][ee] = sc[ee][s][0];
            dw[s][ee] = 0;
            for (int v = 1; v < V; v++)
               if (sc[ee][s][v] < dt[s][ee]) begin
                  dt[s][ee] = sc[ee][s][v];
                  dw[s][ee] = v;
               end
         end
      for (int f = 0; f <= M; f++) acc[0][f] = (f == 0) ? 0 : AMAX;
      for (int l = 1; l <= L; l++) begin
         acc[l][0] = AMAX;
         acc[l][1] = AMAX;
         for (int ee = 2; ee <= M; ee++)
            for (int s = 1; s < ee; s++) begin
               int c;
               c = sat(acc[l-1][s-1], dt[s][ee]);
               if (s == 1 || c < acc[l][ee]) begin
                  acc[l][ee] = c;
                  rbs[l][ee] = s;
                  rbw[l][ee] = dw[s][ee];
               end
            end
      end
      exp_lv = 1;
      exp_total = acc[1][M];
      for (int l = 2; l <= L; l++)
         if (acc[l][M] < exp_total) begin
            exp_total = acc[l][M];
            exp_lv = l;
         end
      e = M;
      for (int k = 0; k < exp_lv; k++) begin
         exp_words[k] = rbw[exp_lv - k][e];
         e = rbs[exp_lv - k][e] - 1;
      end
   endtask

   task automatic push(input int val, input bit poke_start);
      if ($urandom % 3 == 0) @(negedge clk);
      in_valid = 1'b1;
      in_score = SW'(val);
      start = poke_start;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      start = 1'b0;
   endtask

   task automatic run_case(input int idx);
      int n;
      int prevw;
      bit held;
      bit got_last;
      bit rdy;
      int got [0:L];
      build(C_SEED[idx], C_MAX[idx]);
      reference();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int e = 2; e <= M; e++)
         for (int s = 1; s < e; s++)
            for (int v = 0; v < V; v++)
               push(sc[e][s][v], (idx == 1) && (e == 4) && (s == 2));
      // R2: input closes once the final score is in
      chk(in_ready == 1'b0, "R2", "in_ready after last score", int'(in_ready), 0);
      while (!out_valid) @(negedge clk);
      chk(res_total == AW'(exp_total), "R3 R5", "res_total", int'(res_total), exp_total);
      chk(res_levels == 2'(exp_lv), "R6", "res_levels", int'(res_levels), exp_lv);
      n = 0;
      held = 0;
      got_last = 0;
      while (!got_last && n <= L) begin
         rdy = (int'($urandom % 100) < C_RDY[idx]);
         if (idx == 2 && n == 0 && !held) begin
            rdy = 1'b0;
            start = 1'b1;
         end
         out_ready = rdy;
         if (rdy) begin
            got[n] = int'(out_word);
            got_last = out_last;
            n++;
            held = 0;
         end else begin
            prevw = int'(out_word);
            held = 1;
         end
         @(negedge clk);
         start = 1'b0;
         if (held)
            chk(out_valid && int'(out_word) == prevw, "R7", "stalled word held", int'(out_word), prevw);
      end
      out_ready = 1'b0;
      chk(n == exp_lv, "R7", "word count", n, exp_lv);
      for (int k = 0; k < exp_lv && k < n; k++)
         chk(got[k] == exp_words[k], "R1 R4 R7", "traced word", got[k], exp_words[k]);
      chk(done == 1'b1, "R8", "done after final beat", int'(done), 1);
      @(negedge clk);
      chk(done == 1'b0, "R8", "done single cycle", int'(done), 0);
      chk(res_levels == 2'(exp_lv), "R8", "result held", int'(res_levels), exp_lv);
      if (idx == 1 || idx == 2)
         chk(out_valid == 1'b0, "R9", "no extra search after busy start", int'(out_valid), 0);
      if (C_MAX[idx] == 0) begin
         chk(exp_lv == 1 && int'(res_levels) == 1, "R6", "all-equal levels pick fewest", int'(res_levels), 1);
         chk(got[0] == 0, "R1", "all-equal words pick index 0", got[0], 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(in_ready == 1'b0 && out_valid == 1'b0 && done == 1'b0, "R2", "reset outputs quiet",
          int'({in_ready, out_valid, done}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b0, "R2", "idle in_ready", int'(in_ready), 0);
      for (int i = 0; i < NCASE; i++) run_case(i);
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule